// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray Pointers and a Direction Bit

This block moves data words between two unrelated clocks that may both run close to the fastest clock available. The writer and the reader each keep their own pointer in Gray code. Each pointer crosses into the other clock through a short chain of flip-flops. Only one bit of a Gray pointer changes per step, so a sampled pointer is always either the old value or the new value.

The pointers are exactly as wide as the memory address, with no spare wrap bit. When the two pointers match, the FIFO is either completely empty or completely full. A stored direction bit settles which one it is. The bit is set when the write pointer steps into the quarter of the address ring just behind the read pointer, and cleared when the read pointer steps into the quarter just behind the write pointer. Each domain also reports whether at least half of the storage is occupied. Each domain keeps its own copy of the direction bit, built from its own pointer and the synchronized copy of the other pointer.

A producer pushes while `wr_full` is low. A consumer pops while `rd_empty` is low, and the popped word appears on `rd_data` after the read clock edge that accepts the pop. A flag turns on in the same cycle as the local action that causes it. A flag turns off only after the other side's pointer has passed through the synchronizer.

Top module: `gray_dir_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1 and `wr_full`, `wr_half` and `rd_half` are 0.
- R2: Words come out of `rd_data` in the order they were written. Each word appears after the read clock edge that accepts its pop.
- R3: With no reads, the write clock edge that accepts the sixteenth word (depth 16) raises `wr_full`, and the flag is visible right after that edge.
- R4: A push while `wr_full` is 1 is dropped. The words already stored are neither overwritten nor reordered.
- R5: A pop while `rd_empty` is 1 is dropped. `rd_data` keeps its value and the read position does not move.
- R6: The read clock edge that accepts the pop of the last stored word raises `rd_empty` at that same edge.
- R7: After a write into an empty FIFO, `rd_empty` falls within four read clock cycles.
- R8: After a read from a full FIFO, `wr_full` falls within four write clock cycles.
- R9: Each half flag is 1 when its domain's view of the occupancy is at least 8 (half the depth), and 0 below that. A full view counts as 16, and an empty view always gives 0.
- R10: Pointers advance in Gray code, changing one bit per step. After the pointers have wrapped around the ring at several offsets, full and empty are still told apart correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Synchronous active-high reset for the write domain |
| wr_en | input | 1 | Push request |
| wr_data | input | DW (8) | Word to store |
| wr_full | output | 1 | Storage full, write-domain view |
| wr_half | output | 1 | At least half occupied, write-domain view |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Synchronous active-high reset for the read domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW (8) | Word produced by the last accepted pop |
| rd_empty | output | 1 | Storage empty, read-domain view |
| rd_half | output | 1 | At least half occupied, read-domain view |

## Verification
The bench targets the cases where matching pointers are ambiguous. It fills the FIFO to exactly sixteen words and drains it to zero, first from pointer zero and then after shifting the pointers by three places several times. A wrong or missing direction bit would report full as empty, which lets the reader consume stale words, or report empty as full, which stalls the writer. It pushes into a full FIFO and pops from an empty one, then checks the order of the drained words and that `rd_data` holds still. A design that let either request through would corrupt the stored words or skip an entry. It also checks that the half flags switch between seven and eight words and that the flags recover within the synchronizer latency.

// File: rtl/gray_dir_fifo_pkg.sv
package gray_dir_fifo_pkg;

  // Default length of a pointer synchronizer chain.
  localparam int SYNC_STAGES_DEF = 2;

  // The two MSBs of a Gray pointer name one of four ring quarters, in the
  // order 00, 01, 11, 10. Returns 1 when pointer a sits in the quarter that
  // comes just before the quarter of pointer b.
  function automatic logic quad_behind(input logic a_hi, input logic a_lo,
                                       input logic b_hi, input logic b_lo);
    return (a_hi ^ b_lo) & ~(a_lo ^ b_hi);
  endfunction

endpackage

// File: rtl/gray_dir_fifo_sync.sv
module gray_dir_fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gray_dir_fifo_ram.sv
module gray_dir_fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with synchronous reset on the output register.
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/gray_dir_fifo_wr_side.sv
module gray_dir_fifo_wr_side
  import gray_dir_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] rgray_sync,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] wgray,
  output logic          we,
  output logic          full,
  output logic          half
);

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW-1:0] bin_q, bin_n, gray_q, gray_n, fill_n;
  logic          dir_q, dir_n, full_q, full_n, half_q, half_n;
  logic          take, toward_full, toward_empty, eq_n;

  assign take   = push & ~full_q;
  assign bin_n  = bin_q + AW'(take);
  assign gray_n = bin_n ^ (bin_n >> 1);

  // Direction memory, write-domain copy.
  assign toward_full  = quad_behind(gray_n[AW-1], gray_n[AW-2],
                                    rgray_sync[AW-1], rgray_sync[AW-2]);
  assign toward_empty = quad_behind(rgray_sync[AW-1], rgray_sync[AW-2],
                                    gray_n[AW-1], gray_n[AW-2]);
  assign dir_n = toward_full ? 1'b1 : (toward_empty ? 1'b0 : dir_q);

  assign eq_n   = (gray_n == rgray_sync);
  assign fill_n = bin_n - g2b(rgray_sync);
  assign full_n = eq_n & dir_n;
  assign half_n = full_n | fill_n[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
      dir_q  <= 1'b0;
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      bin_q  <= bin_n;
      gray_q <= gray_n;
      dir_q  <= dir_n;
      full_q <= full_n;
      half_q <= half_n;
    end
  end

  assign waddr = bin_q;
  assign wgray = gray_q;
  assign we    = take;
  assign full  = full_q;
  assign half  = half_q;

  // R10
  wr_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  // R4
  push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full_q && push) |=> $stable(gray_q));

  // R9
  full_implies_half_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> half_q);

endmodule

// File: rtl/gray_dir_fifo_rd_side.sv
module gray_dir_fifo_rd_side
  import gray_dir_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic [AW-1:0] wgray_sync,
  output logic [AW-1:0] raddr,
  output logic [AW-1:0] rgray,
  output logic          re,
  output logic          empty,
  output logic          half
);

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW-1:0] bin_q, bin_n, gray_q, gray_n, fill_n;
  logic          dir_q, dir_n, empty_q, empty_n, half_q, half_n;
  logic          take, toward_full, toward_empty, eq_n;

  assign take   = pop & ~empty_q;
  assign bin_n  = bin_q + AW'(take);
  assign gray_n = bin_n ^ (bin_n >> 1);

  // Direction memory, read-domain copy.
  assign toward_full  = quad_behind(wgray_sync[AW-1], wgray_sync[AW-2],
                                    gray_n[AW-1], gray_n[AW-2]);
  assign toward_empty = quad_behind(gray_n[AW-1], gray_n[AW-2],
                                    wgray_sync[AW-1], wgray_sync[AW-2]);
  assign dir_n = toward_full ? 1'b1 : (toward_empty ? 1'b0 : dir_q);

  assign eq_n    = (gray_n == wgray_sync);
  assign fill_n  = g2b(wgray_sync) - bin_n;
  assign empty_n = eq_n & ~dir_n;
  assign half_n  = (eq_n & dir_n) | fill_n[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q   <= '0;
      gray_q  <= '0;
      dir_q   <= 1'b0;
      empty_q <= 1'b1;
      half_q  <= 1'b0;
    end else begin
      bin_q   <= bin_n;
      gray_q  <= gray_n;
      dir_q   <= dir_n;
      empty_q <= empty_n;
      half_q  <= half_n;
    end
  end

  assign raddr = bin_q;
  assign rgray = gray_q;
  assign re    = take;
  assign empty = empty_q;
  assign half  = half_q;

  // R10
  rd_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  // R5
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (empty_q && pop) |=> $stable(gray_q));

  // R9
  empty_clears_half_chk: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> !half_q);

endmodule

// File: rtl/gray_dir_fifo.sv
module gray_dir_fifo
  import gray_dir_fifo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_half,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_half
);

  logic [AW-1:0] waddr, raddr, wgray, rgray, wgray_in_rd, rgray_in_wr;
  logic          we, re;

  gray_dir_fifo_wr_side #(.AW(AW)) wr_side_i (
    .clk(wr_clk), .rst(wr_rst), .push(wr_en), .rgray_sync(rgray_in_wr),
    .waddr(waddr), .wgray(wgray), .we(we), .full(wr_full), .half(wr_half)
  );

  gray_dir_fifo_rd_side #(.AW(AW)) rd_side_i (
    .clk(rd_clk), .rst(rd_rst), .pop(rd_en), .wgray_sync(wgray_in_rd),
    .raddr(raddr), .rgray(rgray), .re(re), .empty(rd_empty), .half(rd_half)
  );

  // Write pointer into the read domain.
  gray_dir_fifo_sync #(.W(AW), .STAGES(SYNC_STAGES)) w2r_sync_i (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_in_rd)
  );

  // Read pointer into the write domain.
  gray_dir_fifo_sync #(.W(AW), .STAGES(SYNC_STAGES)) r2w_sync_i (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_in_wr)
  );

  gray_dir_fifo_ram #(.DW(DW), .AW(AW)) ram_i (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .re(re), .raddr(raddr), .rdata(rd_data)
  );

  // R5
  ignored_pop_data_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_empty && rd_en) |=> $stable(rd_data));

endmodule

// File: tb/gray_dir_fifo_tb_top.sv
module gray_dir_fifo_tb_top;

  localparam int DW          = 8;
  localparam int DEPTH       = 16;
  localparam int WR_PERIOD   = 10;
  localparam int RD_PERIOD   = 14;
  localparam int WATCHDOG_NS = 1000000;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, wr_half, rd_empty, rd_half;

  int n_checks = 0;
  int n_errors = 0;
  logic [DW-1:0] model_q[$];

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  gray_dir_fifo #(.DW(DW), .AW(4)) dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_half(wr_half),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_half(rd_half)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_one(input logic [DW-1:0] v, input bit keep);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge wr_clk);
    wr_en = 1'b0;
    if (keep) model_q.push_back(v);
  endtask

  task automatic pop_one(input string req);
    logic [DW-1:0] exp_v;
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    exp_v = model_q.pop_front();
    chk(req, "popped word", rd_data, exp_v);
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic t_reset();
    chk("R1", "rd_empty after reset", rd_empty, 1);
    chk("R1", "wr_full after reset", wr_full, 0);
    chk("R1", "wr_half after reset", wr_half, 0);
    chk("R1", "rd_half after reset", rd_half, 0);
  endtask

  task automatic t_order();
    push_one(8'h11, 1'b1);
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
    chk("R7", "rd_empty after one write", rd_empty, 0);
    for (int i = 1; i < 5; i++) push_one(8'(8'h11 + 8'h22 * i), 1'b1);
    settle();
    for (int i = 0; i < 4; i++) pop_one("R2");
    chk("R6", "rd_empty before last pop", rd_empty, 0);
    pop_one("R2");
    chk("R6", "rd_empty at last pop", rd_empty, 1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 7; i++) push_one(8'(8'hA0 + i), 1'b1);
    settle();
    chk("R9", "wr_half at 7", wr_half, 0);
    chk("R9", "rd_half at 7", rd_half, 0);
    push_one(8'hA7, 1'b1);
    chk("R9", "wr_half at 8", wr_half, 1);
    settle();
    chk("R9", "rd_half at 8", rd_half, 1);
    for (int i = 8; i < DEPTH - 1; i++) push_one(8'(8'hA0 + i), 1'b1);
    chk("R3", "wr_full at 15", wr_full, 0);
    push_one(8'hAF, 1'b1);
    chk("R3", "wr_full at 16", wr_full, 1);
  endtask

  task automatic t_overflow();
    push_one(8'hEE, 1'b0);
    push_one(8'hEF, 1'b0);
    chk("R4", "wr_full after dropped pushes", wr_full, 1);
    settle();
    chk("R4", "rd_empty while full", rd_empty, 0);
    pop_one("R4");
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    chk("R8", "wr_full after one read", wr_full, 0);
    for (int i = 1; i < DEPTH; i++) pop_one("R4");
    chk("R4", "rd_empty after drain", rd_empty, 1);
    settle();
    chk("R9", "wr_half after drain", wr_half, 0);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] held;
    held = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (2) @(negedge rd_clk);
    rd_en = 1'b0;
    chk("R5", "rd_data after ignored pop", rd_data, held);
    chk("R5", "rd_empty after ignored pop", rd_empty, 1);
    push_one(8'h5A, 1'b1);
    settle();
    pop_one("R5");
    chk("R5", "rd_empty after single pop", rd_empty, 1);
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 3; i++) push_one(8'(8'h30 + 8'h10 * r + i), 1'b1);
      settle();
      for (int i = 0; i < 3; i++) pop_one("R10");
      chk("R10", "rd_empty after shift", rd_empty, 1);
      for (int i = 0; i < DEPTH; i++) push_one(8'(8'hC0 + 8'h05 * r + i), 1'b1);
      chk("R10", "wr_full at offset", wr_full, 1);
      settle();
      chk("R10", "rd_empty while full at offset", rd_empty, 0);
      chk("R10", "rd_half while full at offset", rd_half, 1);
      for (int i = 0; i < DEPTH; i++) pop_one("R10");
      chk("R10", "rd_empty after drain at offset", rd_empty, 1);
      settle();
      chk("R10", "wr_full after drain at offset", wr_full, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge wr_clk);
    wr_rst = 1'b0;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    settle();
    t_reset();
    t_order();
    t_fill();
    t_overflow();
    t_underflow();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule